// File: doc/BRIEF.md
# Down-Counting System Tick Timer

This block is a 24-bit decrementing system timer that raises a periodic tick exception request for an exception arbiter. Software programs a reload value, starts the counter, and chooses whether reaching zero should raise the request. The timer keeps its own pending state. Software can force that state or remove it at any time, and an acknowledge from the arbiter clears it. A 2-bit priority travels next to the request line.

Software reaches the block through a simple word-wide register port. Writes take effect on the clock edge. Reads are combinational from the address. There are four word addresses: 0 is control/status, 1 is reload, 2 is the current value and 3 is priority. The counter's per-cycle action is picked by an enumerated decoder with four actions. CA_ZERO applies on a write to the current value. CA_HOLD applies while the run bit is clear. CA_LOAD applies at zero. CA_DEC applies otherwise. The pending state is a two-state machine. It moves from PD_IDLE to PD_PENDING on a tick event or a software set. It moves from PD_PENDING back to PD_IDLE on a software clear or an acknowledge, but only in a cycle with no set source. In every other case it stays in the state it holds.

Top module: `systick_timer`

## Requirements
- R1: While the run bit (control bit 0) is set and the count is non-zero, the count drops by one per clock. The current value reads at address 2 in bits [23:0], with the upper bits zero.
- R2: While running, a count of zero is replaced by the reload value (address 1, bits [23:0] kept, upper bits read zero) on the next clock, so a tick recurs every reload+1 clocks.
- R3: With the run bit clear, the count holds its value.
- R4: The wrap flag (control bit 16, read-only) sets on the clock where the count goes from 1 to 0. It clears after a read of the control word (rd_en high at address 0) or after any write to address 2. A wrap in the same cycle as the read leaves it set.
- R5: Any write to address 2 makes the count zero, whatever data is written.
- R6: A wrap makes the tick pending only when the interrupt-enable bit (control bit 1) is set.
- R7: Writing the control word with bit 28 set makes the tick pending. Control bit 26 reads back the pending state, and tick_req shows it.
- R8: Writing the control word with bit 27 set, or a one-cycle ack pulse, clears the pending state.
- R9: When a set source (a tick event or bit 28) and a clear source (bit 27 or ack) fall in the same cycle, the tick ends pending.
- R10: The priority sits in bits [31:30] of address 3. The other bits of address 3 read zero. tick_pri carries the stored value.
- R11: After reset the count, reload, control bits, flag, priority and pending state are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the wrap flag when at address 0) |
| addr | input | 2 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| ack | input | 1 | Arbiter acknowledge of the tick exception |
| tick_req | output | 1 | Tick exception pending |
| tick_pri | output | 2 | Tick exception priority |

## Verification
The interesting overlap is a wrap with the interrupt enabled landing on the same clock as a clearing action, either a software clear or an arbiter acknowledge. The bench runs the counter with a small reload and watches the current value through the read port. It clears any stale pending state when the count reads 2. When the count reads 1, it drives the clear or the ack so that it meets the wrap edge. The result is judged on tick_req after that edge, which must be high. A software set and a software clear in one write are judged the same way.

// File: rtl/systick_pkg.sv
package systick_pkg;
    localparam int CNT_W  = 24;
    localparam int DATA_W = 32;
    localparam int PRI_W  = 2;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL    = 2'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CURRENT = 2'd2;
    localparam logic [ADDR_W-1:0] A_PRIO    = 2'd3;

    localparam int B_RUN  = 0;
    localparam int B_IRQ  = 1;
    localparam int B_FLAG = 16;
    localparam int B_PEND = 26;
    localparam int B_PCLR = 27;
    localparam int B_PSET = 28;

    typedef enum logic [1:0] {CA_HOLD, CA_LOAD, CA_DEC, CA_ZERO} cnt_act_e;
    typedef enum logic {PD_IDLE, PD_PENDING} pend_state_e;
endpackage

// File: rtl/systick_counter.sv
module systick_counter
    import systick_pkg::*;
#(
    parameter int W = systick_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         zero_cur,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cur,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    cnt_act_e     act;
    logic [W-1:0] cur_q;
    logic [W-1:0] cur_d;

    always_comb begin
        if (zero_cur)            act = CA_ZERO;
        else if (!run)           act = CA_HOLD;
        else if (cur_q == '0)    act = CA_LOAD;
        else                     act = CA_DEC;
    end

    always_comb begin
        unique case (act)
            CA_ZERO: cur_d = '0;
            CA_HOLD: cur_d = cur_q;
            CA_LOAD: cur_d = reload;
            CA_DEC:  cur_d = cur_q - ONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign cur  = cur_q;
    assign wrap = (act == CA_DEC) && (cur_q == ONE);

    p_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !zero_cur && cur != '0) |=> cur == $past(cur) - ONE);
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !zero_cur && cur == '0) |=> cur == $past(reload));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !zero_cur) |=> $stable(cur));
    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        zero_cur |=> cur == '0);
endmodule

// File: rtl/systick_pend.sv
module systick_pend
    import systick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_evt,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic ack,
    output logic req
);
    pend_state_e state_q, state_d;
    logic set_any, clr_any;

    assign set_any = tick_evt | sw_set;
    assign clr_any = sw_clr | ack;

    always_comb begin
        unique case (state_q)
            PD_IDLE:    state_d = set_any ? PD_PENDING : PD_IDLE;
            PD_PENDING: state_d = (clr_any && !set_any) ? PD_IDLE : PD_PENDING;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req = (state_q == PD_PENDING);
    end

    p_tick_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_evt |=> req);
    p_sw_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set |=> req);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_any && !set_any) |=> !req);
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_any && clr_any) |=> req);
endmodule

// File: rtl/systick_regs.sv
module systick_regs
    import systick_pkg::*;
#(
    parameter int W      = systick_pkg::CNT_W,
    parameter int DW     = systick_pkg::DATA_W,
    parameter int PW     = systick_pkg::PRI_W,
    parameter int AW     = systick_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wrap,
    input  logic          pending,
    input  logic [W-1:0]  cur,
    output logic          run,
    output logic          irq_en,
    output logic [W-1:0]  reload,
    output logic [PW-1:0] prio,
    output logic          zero_cur,
    output logic          sw_set,
    output logic          sw_clr,
    output logic [DW-1:0] rdata
);
    localparam int PRI_LSB = DW - PW;

    logic flag_q;
    logic wr_ctrl, rd_ctrl;
    logic unused_wdata;

    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign rd_ctrl  = rd_en && (addr == A_CTRL);
    assign zero_cur = wr_en && (addr == A_CURRENT);
    assign sw_set   = wr_ctrl && wdata[B_PSET];
    assign sw_clr   = wr_ctrl && wdata[B_PCLR];
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run    <= 1'b0;
            irq_en <= 1'b0;
            reload <= '0;
            prio   <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_CTRL: begin
                    run    <= wdata[B_RUN];
                    irq_en <= wdata[B_IRQ];
                end
                A_RELOAD:  reload <= wdata[W-1:0];
                A_PRIO:    prio   <= wdata[DW-1:PRI_LSB];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    flag_q <= 1'b0;
        else if (wrap)                 flag_q <= 1'b1;
        else if (rd_ctrl || zero_cur)  flag_q <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: begin
                rdata[B_RUN]  = run;
                rdata[B_IRQ]  = irq_en;
                rdata[B_FLAG] = flag_q;
                rdata[B_PEND] = pending;
            end
            A_RELOAD:  rdata[W-1:0] = reload;
            A_CURRENT: rdata[W-1:0] = cur;
            A_PRIO:    rdata[DW-1:PRI_LSB] = prio;
        endcase
    end

    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag_q);
    p_flag_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_ctrl || zero_cur) && !wrap) |=> !flag_q);
endmodule

// File: rtl/systick_timer.sv
module systick_timer
    import systick_pkg::*;
#(
    parameter int W  = systick_pkg::CNT_W,
    parameter int DW = systick_pkg::DATA_W,
    parameter int PW = systick_pkg::PRI_W,
    parameter int AW = systick_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          ack,
    output logic          tick_req,
    output logic [PW-1:0] tick_pri
);
    logic         run, irq_en, zero_cur, sw_set, sw_clr, wrap, tick_evt;
    logic [W-1:0] reload, cur;

    systick_regs #(.W(W), .DW(DW), .PW(PW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .wrap(wrap), .pending(tick_req),
        .cur(cur), .run(run), .irq_en(irq_en), .reload(reload),
        .prio(tick_pri), .zero_cur(zero_cur), .sw_set(sw_set),
        .sw_clr(sw_clr), .rdata(rdata)
    );

    systick_counter #(.W(W)) u_counter (
        .clk(clk), .rst_n(rst_n), .run(run), .zero_cur(zero_cur),
        .reload(reload), .cur(cur), .wrap(wrap)
    );

    assign tick_evt = wrap & irq_en;

    systick_pend u_pend (
        .clk(clk), .rst_n(rst_n), .tick_evt(tick_evt), .sw_set(sw_set),
        .sw_clr(sw_clr), .ack(ack), .req(tick_req)
    );

    p_no_tick_when_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_req && !irq_en && !sw_set) |=> !tick_req);
endmodule

// File: tb/systick_timer_bench.sv
module systick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack = 1'b0;
    logic        tick_req;
    logic [1:0]  tick_pri;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [31:0] RUN  = 32'h1;
    localparam logic [31:0] IRQ  = 32'h2;
    localparam logic [31:0] PCLR = 32'h1 << 27;
    localparam logic [31:0] PSET = 32'h1 << 28;

    always #5 clk = ~clk;

    systick_timer u_systick_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ack(ack), .tick_req(tick_req),
        .tick_pri(tick_pri)
    );

    // {op(1: read-check, 0: write), req(4), addr(2), data(32), expect(32)}
    localparam int NV = 12;
    localparam logic [70:0] VEC [NV] = '{
        {1'b0, 4'd2,  2'd1, 32'h00ABCDEF, 32'h0},
        {1'b1, 4'd2,  2'd1, 32'h0,        32'h00ABCDEF},
        {1'b0, 4'd2,  2'd1, 32'hFFFFFFFF, 32'h0},
        {1'b1, 4'd2,  2'd1, 32'h0,        32'h00FFFFFF},
        {1'b0, 4'd10, 2'd3, 32'hC0000000, 32'h0},
        {1'b1, 4'd10, 2'd3, 32'h0,        32'hC0000000},
        {1'b0, 4'd10, 2'd3, 32'h7FFFFFFF, 32'h0},
        {1'b1, 4'd10, 2'd3, 32'h0,        32'h40000000},
        {1'b0, 4'd6,  2'd0, 32'h00000002, 32'h0},
        {1'b1, 4'd6,  2'd0, 32'h0,        32'h00000002},
        {1'b0, 4'd5,  2'd2, 32'h00000005, 32'h0},
        {1'b1, 4'd5,  2'd2, 32'h0,        32'h00000000}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic rdc(input logic [1:0] a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c0;
        int k;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(tick_req == 1'b0, "R11 tick_req", {31'd0, tick_req}, 32'd0);
        chk(tick_pri == 2'd0, "R11 tick_pri", {30'd0, tick_pri}, 32'd0);
        peek(2'd0, v); chk(v == 32'd0, "R11 ctrl", v, 32'd0);
        peek(2'd2, v); chk(v == 32'd0, "R11 current", v, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        peek(2'd1, v); chk(v == 32'd0, "R11 reload", v, 32'd0);

        // Table walk: register behaviour with the counter stopped
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][70] == 1'b0) begin
                wr(VEC[i][65:64], VEC[i][63:32]);
            end else begin
                rdc(VEC[i][65:64], v);
                chk(v == VEC[i][31:0], $sformatf("R%0d table row %0d", VEC[i][69:66], i), v, VEC[i][31:0]);
            end
        end
        chk(tick_pri == 2'd1, "R10 tick_pri", {30'd0, tick_pri}, 32'd1);

        // R7 / R8 / R9: software pend paths, counter stopped
        wr(2'd0, IRQ | PSET);
        chk(tick_req == 1'b1, "R7 sw set", {31'd0, tick_req}, 32'd1);
        peek(2'd0, v); chk(v[26] == 1'b1, "R7 pend readback", v, 32'h04000002);
        wr(2'd0, IRQ | PCLR);
        chk(tick_req == 1'b0, "R8 sw clear", {31'd0, tick_req}, 32'd0);
        wr(2'd0, IRQ | PSET | PCLR);
        chk(tick_req == 1'b1, "R9 set+clear write", {31'd0, tick_req}, 32'd1);
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        chk(tick_req == 1'b0, "R8 ack clear", {31'd0, tick_req}, 32'd0);

        // R2 / R6: tick period is reload+1
        wr(2'd1, 32'd4);
        wr(2'd2, 32'd0);
        wr(2'd0, RUN | IRQ);
        k = 0;
        while (!tick_req && k < 50) begin @(negedge clk); k++; end
        ack = 1'b1;
        k = 0;
        do begin
            @(negedge clk); ack = 1'b0; k++;
        end while (!tick_req && k < 40);
        chk(k == 5, "R2 tick period", k, 32'd5);
        @(negedge clk);
        peek(2'd2, v); chk(v == 32'd4, "R2 reload at zero", v, 32'd4);
        @(negedge clk);
        peek(2'd2, v); chk(v == 32'd3, "R1 decrement", v, 32'd3);

        // R6: interrupt disabled, wraps do not pend
        wr(2'd0, RUN | PCLR);
        repeat (12) @(negedge clk);
        chk(tick_req == 1'b0, "R6 masked wrap", {31'd0, tick_req}, 32'd0);
        wr(2'd0, 32'd0);
        peek(2'd0, v); chk(v[16] == 1'b1, "R4 flag set", v, 32'h00010000);
        rdc(2'd0, v);
        peek(2'd0, v); chk(v[16] == 1'b0, "R4 flag clear on read", v, 32'd0);

        // R3: hold while stopped
        peek(2'd2, c0);
        repeat (5) @(negedge clk);
        peek(2'd2, v); chk(v == c0, "R3 hold", v, c0);

        // R4 / R5: write to current clears flag and count
        wr(2'd0, RUN);
        repeat (8) @(negedge clk);
        wr(2'd0, 32'd0);
        peek(2'd0, v); chk(v[16] == 1'b1, "R4 flag before current write", v, 32'h00010000);
        wr(2'd2, 32'hDEADBEEF);
        peek(2'd0, v); chk(v[16] == 1'b0, "R4 flag clear on current write", v, 32'd0);
        peek(2'd2, v); chk(v == 32'd0, "R5 current zeroed", v, 32'd0);

        // R9: wrap tick and software clear in the same cycle
        wr(2'd0, RUN | IRQ);
        k = 0;
        do begin @(negedge clk); peek(2'd2, v); k++; end while (v != 32'd2 && k < 20);
        wr_en = 1'b1; addr = 2'd0; wdata = RUN | IRQ | PCLR;
        @(negedge clk);
        wr_en = 1'b0;
        peek(2'd2, v); chk(v == 32'd1, "R1 count at 1", v, 32'd1);
        chk(tick_req == 1'b0, "R8 cleared before wrap", {31'd0, tick_req}, 32'd0);
        wr_en = 1'b1; addr = 2'd0; wdata = RUN | IRQ | PCLR;
        @(negedge clk);
        wr_en = 1'b0;
        chk(tick_req == 1'b1, "R9 tick beats sw clear", {31'd0, tick_req}, 32'd1);

        // R9: wrap tick and ack in the same cycle
        k = 0;
        do begin @(negedge clk); peek(2'd2, v); k++; end while (v != 32'd2 && k < 20);
        wr_en = 1'b1; addr = 2'd0; wdata = RUN | IRQ | PCLR;
        @(negedge clk);
        wr_en = 1'b0;
        chk(tick_req == 1'b0, "R8 cleared before wrap", {31'd0, tick_req}, 32'd0);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(tick_req == 1'b1, "R9 tick beats ack", {31'd0, tick_req}, 32'd1);
        @(negedge clk);
        chk(tick_req == 1'b1, "R9 pending held", {31'd0, tick_req}, 32'd1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule